// File: doc/BRIEF.md
# ACPI PM1 Event Status, Enable and SCI Generator

This block keeps the power-management event status and enable registers of an ACPI-style controller and drives a level-sensitive system control interrupt (SCI) from them. Hardware sources raise status bits through a pulse vector. Software clears a bit by writing a one to it and chooses which events may interrupt through the enable register. Only four sources can ever raise the SCI: timer overflow, global lock, power button and RTC alarm. The block also contains a free-running power-management timer. The timer advances on an external tick and raises the timer status bit each time its most significant bit changes.

The registers are reached through a 64-byte I/O window that the integrator can move. The window base comes from a configuration dword, of which only address bits 15..6 count. A configuration enable bit gates the whole window. Inside the window, the status register is at offset 0x00, the enable register at offset 0x02 and the timer at offset 0x08. The block also drives a timer-arm output. This output tells the surrounding logic when a timer overflow is allowed to produce an interrupt.

Top module: `acpi_pm1_evt`

## Requirements
- R1: After reset the status register, the enable register and the timer read as zero, and both `sci_o` and `tmr_arm_o` are low.
- R2: An access hits the window (`io_hit_o` high) only when `io_valid_i` is high, `win_en_i` is high and address bits 15..6 equal bits 15..6 of `cfg_base_i`. Bits 31..16 and 5..0 of the base are ignored.
- R3: While `win_en_i` is low, no access hits the window. Writes then change no register, and read data is zero.
- R4: Writing the status register (offset 0x00) clears each bit written as 1 and leaves each bit written as 0 unchanged.
- R5: The enable register (offset 0x02) is a plain 16-bit read/write register.
- R6: A pulse on `evt_set_i[k]` sets status bit k. A set and a software clear of the same bit in the same cycle leave the bit set.
- R7: The timer (offset 0x08, read zero-extended) increments by one on each clock that has `pm_tick_i` high and holds otherwise. Writes to it are ignored.
- R8: Status bit 0 is set on the tick that changes the timer's most significant bit, both on the 0-to-1 change and on the 1-to-0 change (wrap).
- R9: `sci_o` is high exactly when status and enable are both set for at least one of bit 0 (timer), bit 5 (global lock), bit 8 (power button) or bit 10 (RTC). It follows a change of either register in the next cycle.
- R10: Any other status bit never drives `sci_o`, even when its enable bit is set.
- R11: `tmr_arm_o` is high exactly when enable bit 0 is set and status bit 0 is clear.
- R12: A read at a window offset other than 0x00, 0x02 or 0x08 returns zero. A write there changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_base_i | input | 32 | Configuration dword that holds the window base |
| win_en_i | input | 1 | Configuration bit that enables the window |
| io_valid_i | input | 1 | I/O access strobe, one cycle per access |
| io_write_i | input | 1 | 1 = write, 0 = read |
| io_addr_i | input | ADDR_W (16) | I/O address |
| io_wdata_i | input | 16 | Write data |
| io_rdata_o | output | DATA_W (32) | Read data, combinational, zero when there is no hit |
| io_hit_o | output | 1 | Access falls inside the enabled window |
| evt_set_i | input | 16 | Hardware event pulses, one per status bit |
| pm_tick_i | input | 1 | Timer advance enable |
| sci_o | output | 1 | Level SCI |
| tmr_arm_o | output | 1 | Timer overflow interrupt armed |

## Verification
The bench builds the block with TMR_W = 8 and keeps the other defaults. This puts both the rising and the wrapping change of the timer's top bit within a few hundred ticks. The bench can then check that the timer status is raised exactly on tick 128 and again on tick 256, and not one tick earlier. The bench uses a base dword with nonzero upper and low bits, so the masking of those bits is observable. With the default widths, the address and status paths are the same as in the full-size block.

// File: rtl/acpi_pm1_pkg.sv
package acpi_pm1_pkg;

  localparam int STS_W = 16;

  // status / enable bit positions of the interrupting sources
  localparam int BIT_TMR    = 0;
  localparam int BIT_GLOCK  = 5;
  localparam int BIT_PWRBTN = 8;
  localparam int BIT_RTC    = 10;

  localparam logic [STS_W-1:0] SCI_SRC_MASK =
    (STS_W'(1) << BIT_TMR)   | (STS_W'(1) << BIT_GLOCK) |
    (STS_W'(1) << BIT_PWRBTN) | (STS_W'(1) << BIT_RTC);

  // register offsets within the window
  localparam int OFF_STS = 'h00;
  localparam int OFF_EN  = 'h02;
  localparam int OFF_TMR = 'h08;

  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_STS  = 2'd1,
    SEL_EN   = 2'd2,
    SEL_TMR  = 2'd3
  } pm1_sel_e;

endpackage

// File: rtl/acpi_pm1_win_dec.sv
module acpi_pm1_win_dec
  import acpi_pm1_pkg::*;
#(
  parameter int ADDR_W   = 16,
  parameter int WIN_LOG2 = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [31:0]       cfg_base_i,
  input  logic              win_en_i,
  input  logic              valid_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              hit_o,
  output pm1_sel_e          sel_o
);

  localparam int TAG_W = ADDR_W - WIN_LOG2;

  logic [TAG_W-1:0]    addr_tag;
  logic [TAG_W-1:0]    base_tag;
  logic [WIN_LOG2-1:0] offset;
  logic                tag_match;
  logic                unused_ok;

  assign addr_tag  = addr_i[ADDR_W-1:WIN_LOG2];
  assign base_tag  = cfg_base_i[ADDR_W-1:WIN_LOG2];
  assign offset    = addr_i[WIN_LOG2-1:0];
  assign tag_match = (addr_tag == base_tag);
  assign hit_o     = valid_i & win_en_i & tag_match;

  // base bits outside the decoded tag carry no meaning
  assign unused_ok = ^{cfg_base_i[31:ADDR_W], cfg_base_i[WIN_LOG2-1:0]};

  always_comb begin
    sel_o = SEL_NONE;
    if (hit_o) begin
      if (int'(offset) == OFF_STS)      sel_o = SEL_STS;
      else if (int'(offset) == OFF_EN)  sel_o = SEL_EN;
      else if (int'(offset) == OFF_TMR) sel_o = SEL_TMR;
      else                              sel_o = SEL_NONE;
    end
  end

  a_r3_gated_by_enable: assert property (@(posedge clk) disable iff (!rst_n)
    hit_o |-> win_en_i);

  a_r2_tag_match: assert property (@(posedge clk) disable iff (!rst_n)
    hit_o |-> (addr_i[ADDR_W-1:WIN_LOG2] == cfg_base_i[ADDR_W-1:WIN_LOG2]));

  a_r12_sel_needs_hit: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_o != SEL_NONE) |-> hit_o);

endmodule

// File: rtl/acpi_pm1_tmr.sv
module acpi_pm1_tmr #(
  parameter int TMR_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  output logic [TMR_W-1:0] cnt_o,
  output logic             ovf_o
);

  localparam int MSB = TMR_W - 1;

  logic [TMR_W-1:0] cnt_q;
  logic [TMR_W-1:0] cnt_inc;

  assign cnt_inc = cnt_q + TMR_W'(1);
  assign ovf_o   = tick_i & (cnt_inc[MSB] ^ cnt_q[MSB]);
  assign cnt_o   = cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (tick_i) begin
      cnt_q <= cnt_inc;
    end
  end

  a_r7_hold_without_tick: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_i |=> $stable(cnt_q));

  a_r7_step_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    tick_i |=> (cnt_q == TMR_W'($past(cnt_q) + 1'b1)));

  a_r8_ovf_only_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_o |-> tick_i);

  a_r8_ovf_at_carry: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_i && (cnt_q[MSB-1:0] == '1)) |-> ovf_o);

endmodule

// File: rtl/acpi_pm1_evt_regs.sv
module acpi_pm1_evt_regs #(
  parameter int STS_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sts_wr_i,
  input  logic             en_wr_i,
  input  logic [STS_W-1:0] wdata_i,
  input  logic [STS_W-1:0] set_i,
  output logic [STS_W-1:0] sts_o,
  output logic [STS_W-1:0] en_o
);

  logic [STS_W-1:0] sts_q, sts_d;
  logic [STS_W-1:0] en_q, en_d;
  logic             sts_ce, en_ce;

  // next state: software clear first, hardware set applied last so it wins
  always_comb begin
    sts_d = sts_q;
    if (sts_wr_i) begin
      sts_d = sts_d & ~wdata_i;
    end
    sts_d  = sts_d | set_i;
    sts_ce = sts_wr_i | (|set_i);
  end

  always_comb begin
    en_d  = wdata_i;
    en_ce = en_wr_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sts_q <= '0;
    end else if (sts_ce) begin
      sts_q <= sts_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q <= '0;
    end else if (en_ce) begin
      en_q <= en_d;
    end
  end

  assign sts_o = sts_q;
  assign en_o  = en_q;

  a_r6_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (set_i != '0) |=> ((sts_q & $past(set_i)) == $past(set_i)));

  a_r4_w1c: assert property (@(posedge clk) disable iff (!rst_n)
    (sts_wr_i && (set_i == '0)) |=> (sts_q == ($past(sts_q) & ~$past(wdata_i))));

  a_r4_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!sts_wr_i && (set_i == '0)) |=> $stable(sts_q));

  a_r5_enable_rw: assert property (@(posedge clk) disable iff (!rst_n)
    en_wr_i |=> (en_q == $past(wdata_i)));

endmodule

// File: rtl/acpi_pm1_evt.sv
module acpi_pm1_evt
  import acpi_pm1_pkg::*;
#(
  parameter int ADDR_W   = 16,
  parameter int DATA_W   = 32,
  parameter int TMR_W    = 24,
  parameter int WIN_LOG2 = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [31:0]       cfg_base_i,
  input  logic              win_en_i,
  input  logic              io_valid_i,
  input  logic              io_write_i,
  input  logic [ADDR_W-1:0] io_addr_i,
  input  logic [15:0]       io_wdata_i,
  output logic [DATA_W-1:0] io_rdata_o,
  output logic              io_hit_o,
  input  logic [15:0]       evt_set_i,
  input  logic              pm_tick_i,
  output logic              sci_o,
  output logic              tmr_arm_o
);

  logic             hit;
  pm1_sel_e         sel;
  logic             wr_sts, wr_en;
  logic [STS_W-1:0] sts, en, set_vec;
  logic [TMR_W-1:0] tmr_cnt;
  logic             tmr_ovf;
  logic [STS_W-1:0] pending;

  acpi_pm1_win_dec #(
    .ADDR_W   (ADDR_W),
    .WIN_LOG2 (WIN_LOG2)
  ) u_dec (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_base_i (cfg_base_i),
    .win_en_i   (win_en_i),
    .valid_i    (io_valid_i),
    .addr_i     (io_addr_i),
    .hit_o      (hit),
    .sel_o      (sel)
  );

  acpi_pm1_tmr #(
    .TMR_W (TMR_W)
  ) u_tmr (
    .clk    (clk),
    .rst_n  (rst_n),
    .tick_i (pm_tick_i),
    .cnt_o  (tmr_cnt),
    .ovf_o  (tmr_ovf)
  );

  always_comb begin
    set_vec          = evt_set_i;
    set_vec[BIT_TMR] = evt_set_i[BIT_TMR] | tmr_ovf;
  end

  assign wr_sts = io_write_i & (sel == SEL_STS);
  assign wr_en  = io_write_i & (sel == SEL_EN);

  acpi_pm1_evt_regs #(
    .STS_W (STS_W)
  ) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .sts_wr_i (wr_sts),
    .en_wr_i  (wr_en),
    .wdata_i  (io_wdata_i),
    .set_i    (set_vec),
    .sts_o    (sts),
    .en_o     (en)
  );

  always_comb begin
    io_rdata_o = '0;
    if (!io_write_i) begin
      case (sel)
        SEL_STS: io_rdata_o = DATA_W'(sts);
        SEL_EN:  io_rdata_o = DATA_W'(en);
        SEL_TMR: io_rdata_o = DATA_W'(tmr_cnt);
        default: io_rdata_o = '0;
      endcase
    end
  end

  assign pending   = sts & en & SCI_SRC_MASK;
  assign sci_o     = |pending;
  assign tmr_arm_o = en[BIT_TMR] & ~sts[BIT_TMR];
  assign io_hit_o  = hit;

  a_r9_sci_has_source: assert property (@(posedge clk) disable iff (!rst_n)
    sci_o |-> ((sts[BIT_TMR] & en[BIT_TMR]) | (sts[BIT_GLOCK] & en[BIT_GLOCK]) |
               (sts[BIT_PWRBTN] & en[BIT_PWRBTN]) | (sts[BIT_RTC] & en[BIT_RTC])));

  a_r10_other_bits_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (((sts & en) & ~SCI_SRC_MASK) == (sts & en)) |-> !sci_o);

  a_r11_arm_rule: assert property (@(posedge clk) disable iff (!rst_n)
    tmr_arm_o |-> (en[BIT_TMR] && !sts[BIT_TMR]));

  a_r3_no_write_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    (!win_en_i && (evt_set_i == '0) && !pm_tick_i) |=> ($stable(sts) && $stable(en)));

endmodule

// File: tb/tb_acpi_pm1_evt.sv
`timescale 1ns/1ps
module tb_acpi_pm1_evt;

  localparam int TW = 8;
  localparam logic [15:0] A_STS = 16'hB000;
  localparam logic [15:0] A_EN  = 16'hB002;
  localparam logic [15:0] A_TMR = 16'hB008;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [31:0] cfg_base;
  logic        win_en;
  logic        io_valid, io_write;
  logic [15:0] io_addr, io_wdata;
  logic [31:0] io_rdata;
  logic        io_hit;
  logic [15:0] evt_set;
  logic        tick;
  logic        sci, arm;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;
  int exp_tmr = 0;

  always #2 clk = ~clk;

  acpi_pm1_evt #(.TMR_W(TW)) dut (
    .clk(clk), .rst_n(rst_n), .cfg_base_i(cfg_base), .win_en_i(win_en),
    .io_valid_i(io_valid), .io_write_i(io_write), .io_addr_i(io_addr),
    .io_wdata_i(io_wdata), .io_rdata_o(io_rdata), .io_hit_o(io_hit),
    .evt_set_i(evt_set), .pm_tick_i(tick), .sci_o(sci), .tmr_arm_o(arm)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [15:0] a, input logic [15:0] d);
    @(negedge clk);
    io_valid = 1; io_write = 1; io_addr = a; io_wdata = d;
    @(negedge clk);
    io_valid = 0; io_write = 0;
  endtask

  task automatic bus_rd(input logic [15:0] a, output logic [31:0] d, output logic h);
    @(negedge clk);
    io_valid = 1; io_write = 0; io_addr = a;
    #1;
    d = io_rdata; h = io_hit;
    io_valid = 0;
  endtask

  task automatic pulse(input logic [15:0] v);
    @(negedge clk); evt_set = v;
    @(negedge clk); evt_set = '0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick = 1;
    end
    @(negedge clk); tick = 0;
    exp_tmr = (exp_tmr + n) % (1 << TW);
  endtask

  task automatic t_reset();
    logic [31:0] d; logic h;
    #1;
    chk("R1 sci", 32'(sci), 0);
    chk("R1 arm", 32'(arm), 0);
    bus_rd(A_STS, d, h); chk("R1 status", d, 0);
    bus_rd(A_EN, d, h);  chk("R1 enable", d, 0);
    bus_rd(A_TMR, d, h); chk("R1 timer", d, 0);
  endtask

  task automatic t_window();
    logic [31:0] d; logic h;
    bus_rd(16'hB03F, d, h); chk("R2 hit at top of window", 32'(h), 1);
    chk("R12 unmapped offset reads zero", d, 0);
    bus_rd(16'hB040, d, h); chk("R2 miss above window", 32'(h), 0);
    bus_rd(16'hAFFE, d, h); chk("R2 miss below window", 32'(h), 0);
    bus_wr(A_EN, 16'hFFFF); bus_rd(A_EN, d, h); chk("R5 enable all ones", d, 32'hFFFF);
    bus_wr(A_EN, 16'h0420); bus_rd(A_EN, d, h); chk("R5 enable pattern", d, 32'h0420);
    bus_wr(16'hB004, 16'hFFFF); bus_rd(A_EN, d, h); chk("R12 write to unmapped offset", d, 32'h0420);
    bus_wr(A_EN, 16'h0000);
  endtask

  task automatic t_disabled();
    logic [31:0] d; logic h;
    @(negedge clk); win_en = 0;
    bus_wr(A_EN, 16'h1234);
    bus_rd(A_EN, d, h);
    chk("R3 no hit while off", 32'(h), 0);
    chk("R3 read zero while off", d, 0);
    @(negedge clk); win_en = 1;
    bus_rd(A_EN, d, h); chk("R3 write ignored while off", d, 0);
  endtask

  task automatic t_w1c();
    logic [31:0] d; logic h;
    pulse(16'h0126);
    bus_rd(A_STS, d, h); chk("R6 hardware set", d, 32'h0126);
    bus_wr(A_STS, 16'h0022); bus_rd(A_STS, d, h); chk("R4 clear selected", d, 32'h0104);
    bus_wr(A_STS, 16'h0000); bus_rd(A_STS, d, h); chk("R4 zero write keeps", d, 32'h0104);
    bus_wr(A_STS, 16'hFFFF); bus_rd(A_STS, d, h); chk("R4 clear all", d, 0);
  endtask

  task automatic t_set_wins();
    logic [31:0] d; logic h;
    pulse(16'h0100);
    @(negedge clk);
    io_valid = 1; io_write = 1; io_addr = A_STS; io_wdata = 16'h0100; evt_set = 16'h0100;
    @(negedge clk);
    io_valid = 0; io_write = 0; evt_set = '0;
    bus_rd(A_STS, d, h); chk("R6 set beats clear", d, 32'h0100);
    bus_wr(A_STS, 16'hFFFF);
  endtask

  task automatic t_sci();
    int srcs[4] = '{0, 5, 8, 10};
    foreach (srcs[i]) begin
      bus_wr(A_EN, 16'(1 << srcs[i]));
      pulse(16'(1 << srcs[i]));
      #1; chk($sformatf("R9 source bit %0d", srcs[i]), 32'(sci), 1);
      bus_wr(A_STS, 16'hFFFF);
      #1; chk($sformatf("R9 drop after clear bit %0d", srcs[i]), 32'(sci), 0);
    end
    bus_wr(A_EN, 16'h0000);
    pulse(16'h0020);
    #1; chk("R9 status without enable", 32'(sci), 0);
    bus_wr(A_EN, 16'h0020);
    #1; chk("R9 follows enable write", 32'(sci), 1);
    bus_wr(A_STS, 16'hFFFF);
    bus_wr(A_EN, 16'hFADE);
    pulse(16'hFADE);
    #1; chk("R10 other bits silent", 32'(sci), 0);
    bus_wr(A_STS, 16'hFFFF);
    bus_wr(A_EN, 16'h0000);
  endtask

  task automatic t_timer();
    logic [31:0] d; logic h;
    bus_wr(A_EN, 16'h0001);
    #1; chk("R11 armed", 32'(arm), 1);
    ticks(10);
    bus_rd(A_TMR, d, h); chk("R7 count", d, 32'(exp_tmr));
    bus_wr(A_TMR, 16'h00FF);
    bus_rd(A_TMR, d, h); chk("R7 write ignored", d, 32'(exp_tmr));
    repeat (5) @(negedge clk);
    bus_rd(A_TMR, d, h); chk("R7 holds without tick", d, 32'(exp_tmr));
    ticks(127 - exp_tmr);
    bus_rd(A_STS, d, h); chk("R8 not yet at 127", d, 0);
    ticks(1);
    bus_rd(A_STS, d, h); chk("R8 rise of top bit", d, 1);
    #1; chk("R9 timer sci", 32'(sci), 1);
    chk("R11 disarmed", 32'(arm), 0);
    bus_rd(A_TMR, d, h); chk("R7 at 128", d, 32'h80);
    bus_wr(A_STS, 16'h0001);
    #1; chk("R11 rearmed", 32'(arm), 1);
    ticks(127);
    bus_rd(A_STS, d, h); chk("R8 not yet before wrap", d, 0);
    ticks(1);
    bus_rd(A_STS, d, h); chk("R8 wrap of top bit", d, 1);
    bus_rd(A_TMR, d, h); chk("R7 wrapped", d, 0);
    bus_wr(A_STS, 16'hFFFF);
  endtask

  task automatic report();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    rst_n = 0; cfg_base = 32'h5A5A_B03F; win_en = 1;
    io_valid = 0; io_write = 0; io_addr = '0; io_wdata = '0;
    evt_set = '0; tick = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_window();
    t_disabled();
    t_w1c();
    t_set_wins();
    t_sci();
    t_timer();
    report();
  end

  initial begin
    #400000;
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
  end

endmodule